// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block turns two already-synchronized command bits into the gate commands for the two switches of a half-bridge. The high-side command drives the main switch and the low-side command drives the synchronous rectifier. A static two-bit mode input picks how the commands are interpreted. In single-PWM mode, one input enables the bridge and the other selects the side. The outputs are complementary, and both stay low for a programmable number of clock cycles at each handover. In the two independent modes, each input drives its own output. One of those modes passes the inputs straight through. The other blocks any cycle in which both inputs ask for conduction.

Dead time is programmed separately for each direction, as a count of clock cycles. Every output and the mode-error flag come from a register, so each output follows the inputs sampled at the previous rising edge. The mode may only be changed while reset is asserted.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While `rst` is sampled high, the next edge drives `gate_hi`, `gate_lo` and `mode_err` to 0 and clears any dead-time count in progress. After release, a side always waits its full dead time before it turns on.
- R2: The mode is decoded as 2'b00 single-PWM, 2'b01 independent pass-through and 2'b10 independent interlocked. The code 2'b11 is invalid: one edge later both gates are 0 and `mode_err` is 1. `mode_err` is 0 in every valid mode. The mode changes only while `rst` is high.
- R3: In single-PWM mode with `cmd_hi` sampled 0, both gates are 0 after the next edge, whatever `cmd_lo` is.
- R4: In single-PWM mode with `cmd_hi` at 1 and the dead time elapsed, `cmd_lo`=1 gives `gate_hi`=1 and `gate_lo`=0, and `cmd_lo`=0 gives `gate_hi`=0 and `gate_lo`=1.
- R5: In single-PWM mode, a request for the high side is first sampled at edge k, with N the value of `dly_to_hi` at edge k. Both gates are 0 after edges k through k+N-1, and `gate_hi` rises at edge k+N. With N=0, `gate_hi` rises at edge k. The same holds when the request comes from the off state.
- R6: The low side follows the same rule as R5, using `dly_to_lo`.
- R7: If the requested side changes before a dead time has expired, the count restarts from the programmed value for the newly requested side.
- R8: In single-PWM and interlocked modes, `gate_hi` and `gate_lo` are never 1 together.
- R9: In pass-through mode, `gate_hi` equals the previous cycle's `cmd_hi` and `gate_lo` equals the previous cycle's `cmd_lo`. Both may be 1 at once.
- R10: In interlocked mode, `cmd_hi`=`cmd_lo`=1 gives both gates 0 one edge later. Otherwise the gates follow the inputs as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode select (static) |
| cmd_hi | input | 1 | Enable (PWM mode) / high-side command (independent modes) |
| cmd_lo | input | 1 | PWM (PWM mode) / low-side command (independent modes) |
| dly_to_lo | input | DT_W | Dead-time cycles before the low side turns on |
| dly_to_hi | input | DT_W | Dead-time cycles before the high side turns on |
| gate_hi | output | 1 | High-side (main switch) gate command |
| gate_lo | output | 1 | Low-side (synchronous rectifier) gate command |
| mode_err | output | 1 | Invalid mode code seen |

## Verification
The bench builds the block with the default count width of 8 bits. At run time it programs the dead-time counts to 0, 2 and 3. With the short counts, every idle cycle and the exact rising edge can be checked one by one. The zero count covers the direct-switch path. Unequal counts in the two directions show that each handover uses its own count. They also show that a restart reloads the count of the newly requested side, not the old one.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [1:0] {
        MODE_PWM = 2'b00,
        MODE_IND = 2'b01,
        MODE_ILK = 2'b10,
        MODE_BAD = 2'b11
    } hb_mode_e;

    typedef enum logic [2:0] {
        DT_OFF,
        DT_WAIT_HI,
        DT_WAIT_LO,
        DT_HI,
        DT_LO
    } dt_state_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_HI,
        REQ_LO
    } side_req_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    function automatic side_req_e pwm_request(logic enable, logic pwm);
        if (!enable)
            return REQ_NONE;
        return pwm ? REQ_HI : REQ_LO;
    endfunction

    function automatic gate_pair_t direct_map(logic hi_in, logic lo_in, logic interlock);
        gate_pair_t g;
        g.hi = hi_in && !(interlock && lo_in);
        g.lo = lo_in && !(interlock && hi_in);
        return g;
    endfunction

endpackage

// File: rtl/hb_pwm_deadtime.sv
module hb_pwm_deadtime
    import hb_gate_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            enable,
    input  logic            pwm,
    input  logic [DT_W-1:0] dly_to_lo,
    input  logic [DT_W-1:0] dly_to_hi,
    output gate_pair_t      gates
);

    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    dt_state_e       state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;
    side_req_e       req;

    always_comb begin
        req     = active ? pwm_request(enable, pwm) : REQ_NONE;
        state_d = state_q;
        cnt_d   = cnt_q;
        case (req)
            REQ_HI: begin
                if (state_q == DT_WAIT_HI) begin
                    if (cnt_q <= CNT_ONE) begin
                        state_d = DT_HI;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end else if (state_q != DT_HI) begin
                    if (dly_to_hi == '0) begin
                        state_d = DT_HI;
                        cnt_d   = '0;
                    end else begin
                        state_d = DT_WAIT_HI;
                        cnt_d   = dly_to_hi;
                    end
                end
            end
            REQ_LO: begin
                if (state_q == DT_WAIT_LO) begin
                    if (cnt_q <= CNT_ONE) begin
                        state_d = DT_LO;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end else if (state_q != DT_LO) begin
                    if (dly_to_lo == '0) begin
                        state_d = DT_LO;
                        cnt_d   = '0;
                    end else begin
                        state_d = DT_WAIT_LO;
                        cnt_d   = dly_to_lo;
                    end
                end
            end
            default: begin
                state_d = DT_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DT_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign gates.hi = (state_q == DT_HI);
    assign gates.lo = (state_q == DT_LO);

endmodule

// File: rtl/hb_direct_path.sv
module hb_direct_path
    import hb_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       interlock,
    input  logic       hi_in,
    input  logic       lo_in,
    output gate_pair_t gates
);

    always_ff @(posedge clk) begin
        if (rst)
            gates <= '0;
        else
            gates <= direct_map(hi_in, lo_in, interlock);
    end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_gate_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic            cmd_hi,
    input  logic            cmd_lo,
    input  logic [DT_W-1:0] dly_to_lo,
    input  logic [DT_W-1:0] dly_to_hi,
    output logic            gate_hi,
    output logic            gate_lo,
    output logic            mode_err
);

    hb_mode_e   mode_in;
    hb_mode_e   mode_q;
    gate_pair_t pwm_gates;
    gate_pair_t dir_gates;
    gate_pair_t out_gates;

    assign mode_in = hb_mode_e'(mode);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_PWM;
        else
            mode_q <= mode_in;
    end

    hb_pwm_deadtime #(.DT_W(DT_W)) u_deadtime (
        .clk       (clk),
        .rst       (rst),
        .active    (mode_in == MODE_PWM),
        .enable    (cmd_hi),
        .pwm       (cmd_lo),
        .dly_to_lo (dly_to_lo),
        .dly_to_hi (dly_to_hi),
        .gates     (pwm_gates)
    );

    hb_direct_path u_direct (
        .clk       (clk),
        .rst       (rst),
        .interlock (mode_in == MODE_ILK),
        .hi_in     (cmd_hi),
        .lo_in     (cmd_lo),
        .gates     (dir_gates)
    );

    always_comb begin
        case (mode_q)
            MODE_PWM:           out_gates = pwm_gates;
            MODE_IND, MODE_ILK: out_gates = dir_gates;
            default:            out_gates = '0;
        endcase
    end

    assign gate_hi  = out_gates.hi;
    assign gate_lo  = out_gates.lo;
    assign mode_err = (mode_q == MODE_BAD);

endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk
    import hb_gate_pkg::*;
#(
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      mode,
    input logic            cmd_hi,
    input logic            cmd_lo,
    input logic [DT_W-1:0] dly_to_lo,
    input logic [DT_W-1:0] dly_to_hi,
    input logic            gate_hi,
    input logic            gate_lo,
    input logic            mode_err
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!gate_hi && !gate_lo && !mode_err)); // R1

    AST_BAD_MODE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BAD) |=> (mode_err && !gate_hi && !gate_lo)); // R2

    AST_PWM_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PWM && !cmd_hi) |=> (!gate_hi && !gate_lo)); // R3

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_IND) |-> !(gate_hi && gate_lo)); // R8

    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IND) |=> (gate_hi == $past(cmd_hi) && gate_lo == $past(cmd_lo))); // R9

    AST_INTERLOCK_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ILK && cmd_hi && cmd_lo) |=> (!gate_hi && !gate_lo)); // R10

endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(.DT_W(DT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .cmd_hi    (cmd_hi),
    .cmd_lo    (cmd_lo),
    .dly_to_lo (dly_to_lo),
    .dly_to_hi (dly_to_hi),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .mode_err  (mode_err)
);

// File: tb/hb_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hb_gate_ctrl_bench;

    localparam int DT_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      mode = 2'b00;
    logic            cmd_hi = 1'b0;
    logic            cmd_lo = 1'b0;
    logic [DT_W-1:0] dly_to_lo = '0;
    logic [DT_W-1:0] dly_to_hi = '0;
    logic            gate_hi, gate_lo, mode_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic  ho;
        logic  lo;
        logic  err;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    hb_gate_ctrl #(.DT_W(DT_W)) u_hb_gate_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cmd_hi    (cmd_hi),
        .cmd_lo    (cmd_lo),
        .dly_to_lo (dly_to_lo),
        .dly_to_hi (dly_to_hi),
        .gate_hi   (gate_hi),
        .gate_lo   (gate_lo),
        .mode_err  (mode_err)
    );

    task automatic drv(input logic r, input logic e, input logic p,
                       input logic eh, input logic el, input logic ee, input string tag);
        exp_t it;
        @(negedge clk);
        rst    = r;
        cmd_hi = e;
        cmd_lo = p;
        it.ho  = eh;
        it.lo  = el;
        it.err = ee;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic restart(input logic [1:0] m);
        @(negedge clk);
        mode = m;
        drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 reset");
        drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 reset");
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                total++;
                if (gate_hi !== it.ho || gate_lo !== it.lo || mode_err !== it.err) begin
                    bad++;
                    $display("FAIL %s: got hi=%b lo=%b err=%b expected hi=%b lo=%b err=%b",
                             it.tag, gate_hi, gate_lo, mode_err, it.ho, it.lo, it.err);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        // single-PWM mode, unequal dead times
        dly_to_hi = 8'd3;
        dly_to_lo = 8'd2;
        restart(2'b00);
        drv(0, 0, 1, 0, 0, 0, "R3 disabled pwm=1");
        drv(0, 0, 0, 0, 0, 0, "R3 disabled pwm=0");
        drv(0, 1, 1, 0, 0, 0, "R5 dead k");
        drv(0, 1, 1, 0, 0, 0, "R5 dead k+1");
        drv(0, 1, 1, 0, 0, 0, "R5 dead k+2");
        drv(0, 1, 1, 1, 0, 0, "R5 high on k+3");
        drv(0, 1, 1, 1, 0, 0, "R4 high steady");
        drv(0, 1, 0, 0, 0, 0, "R6 dead k");
        drv(0, 1, 0, 0, 0, 0, "R6 dead k+1");
        drv(0, 1, 0, 0, 1, 0, "R6 low on k+2");
        drv(0, 1, 0, 0, 1, 0, "R4 low steady");
        drv(0, 1, 1, 0, 0, 0, "R7 wait hi load");
        drv(0, 1, 1, 0, 0, 0, "R7 wait hi count");
        drv(0, 1, 0, 0, 0, 0, "R7 reload lo");
        drv(0, 1, 0, 0, 0, 0, "R7 lo counting");
        drv(0, 1, 0, 0, 1, 0, "R7 low on after reload");
        drv(0, 0, 0, 0, 0, 0, "R3 disable from low");
        drv(0, 0, 1, 0, 0, 0, "R3 disable ignores pwm");
        // reset mid-run clears the count
        drv(0, 1, 1, 0, 0, 0, "R5 dead k");
        drv(0, 1, 1, 0, 0, 0, "R5 dead k+1");
        drv(1, 1, 1, 0, 0, 0, "R1 reset in wait");
        drv(0, 1, 1, 0, 0, 0, "R1 full wait k");
        drv(0, 1, 1, 0, 0, 0, "R1 full wait k+1");
        drv(0, 1, 1, 0, 0, 0, "R1 full wait k+2");
        drv(0, 1, 1, 1, 0, 0, "R1 high after full wait");
        drv(1, 1, 1, 0, 0, 0, "R1 reset from high");
        // zero dead time
        dly_to_hi = 8'd0;
        dly_to_lo = 8'd0;
        drv(0, 1, 1, 1, 0, 0, "R5 zero dead high");
        drv(0, 1, 0, 0, 1, 0, "R6 zero dead low");
        drv(0, 1, 1, 1, 0, 0, "R4 zero dead high");
        // pass-through mode
        restart(2'b01);
        drv(0, 0, 0, 0, 0, 0, "R9 00");
        drv(0, 0, 1, 0, 1, 0, "R9 01");
        drv(0, 1, 0, 1, 0, 0, "R9 10");
        drv(0, 1, 1, 1, 1, 0, "R9 11 both on");
        drv(0, 0, 0, 0, 0, 0, "R9 back to 00");
        // interlocked mode
        restart(2'b10);
        drv(0, 1, 1, 0, 0, 0, "R10 11 blocked");
        drv(0, 1, 0, 1, 0, 0, "R10 10");
        drv(0, 0, 1, 0, 1, 0, "R10 01");
        drv(0, 1, 1, 0, 0, 0, "R10 11 blocked again");
        drv(0, 0, 0, 0, 0, 0, "R10 00");
        // invalid mode code
        restart(2'b11);
        drv(0, 1, 1, 0, 0, 1, "R2 invalid 11");
        drv(0, 1, 0, 0, 0, 1, "R2 invalid 10");
        drv(0, 0, 1, 0, 0, 1, "R2 invalid 01");
        restart(2'b01);
        drv(0, 1, 0, 1, 0, 0, "R2 err clears in valid mode");
        drv(0, 0, 0, 0, 0, 0, "R2 idle");
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule